// File: doc/BRIEF.md
# Paused-Step Integer Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder. Signed and unsigned operands are both handled. It is meant to sit beside a processor's execution pipeline. There the divide is issued as a repeated instruction, and the repeat loop supplies one step-enable pulse for each iteration.

A divide spends exactly nineteen step-enabled clocks. The first sets up operand magnitudes and the error flags. The next sixteen each form one quotient bit by restoring subtraction. The last two apply the sign correction and then register the results. The step enable may be held low for any number of clocks between any two steps, for example while an interrupt is serviced. Every piece of partial state holds its value during such a pause, and the divide resumes with no effect on the result.

Top module: `stepDivider`

## Requirements
- R1: A start pulse while idle captures the operands and mode inputs, and busy is high from the next clock. A start pulse while busy has no effect, and operand inputs are not sampled after the capture. step_en while idle does not start a divide.
- R2: A divide needs exactly 19 clocks with step_en high while busy. busy stays high and done low until the 19th of them. At that edge busy falls and done rises for exactly one clock.
- R3: While step_en is low, the divide's progress and partial state are held. A divide paused any number of times and for any length gives the same results as one run without pauses.
- R4: With wideMode=0 and signedMode=0, only dividend[15:0] is used. The results are the unsigned quotient and remainder of dividend[15:0] divided by divisor.
- R5: With wideMode=1 and signedMode=0, the full 32-bit dividend is divided unsigned by the divisor.
- R6: With signedMode=1, the operands are treated as two's complement. In 16/16 mode the dividend is dividend[15:0]. The quotient is truncated toward zero, and the nonzero remainder takes the sign of the dividend.
- R7: A zero divisor sets divZero, forces the quotient to 0xFFFF and the remainder to dividend[15:0], and clears overflow. It still takes 19 steps.
- R8: In 32/16 mode, overflow is set when the true quotient does not fit in 16 bits: above 65535 if unsigned, outside -32768..32767 if signed. In that case quotient and remainder are undefined. In 16/16 mode overflow is never set, and -32768 / -1 gives quotient 0x8000 with remainder 0.
- R9: During and after reset, busy, done, quotient, remainder, divZero and overflow are all zero.
- R10: quotient, remainder, divZero and overflow change only at the final step of a divide. They hold between divides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a divide (ignored while busy) |
| dividend | input | 32 | Dividend; low half only in 16/16 mode |
| divisor | input | 16 | Divisor |
| wideMode | input | 1 | 1 = 32/16 divide, 0 = 16/16 divide |
| signedMode | input | 1 | 1 = two's complement operands |
| stepEn | input | 1 | Advance one step at this clock |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-clock pulse after the final step |
| quotient | output | 16 | Quotient of the last divide |
| remainder | output | 16 | Remainder of the last divide |
| divZero | output | 1 | Last divide had a zero divisor |
| overflow | output | 1 | Last 32/16 quotient did not fit |

## Verification
The hardest situation to reach is a divide held in the middle of its bit iterations for a long time, or interrupted several times, while other inputs move. The stimulus withholds step_en for several clocks at regular step positions and, in one run, for forty clocks. It then compares the results with the known answers. In another run, start is pulsed and the operand inputs are changed partway through a divide, to show that neither disturbs the captured work. The signed 32/16 boundary is also hard to reach. There the magnitude quotient is exactly 32768: it passes when the result is negative and overflows when it is positive. Table entries aim at both sides of that boundary.

// File: rtl/stepDivPkg.sv
package stepDivPkg;
  typedef struct packed {
    logic load;
    logic setup;
    logic iter;
    logic fix;
    logic wb;
  } divStrobes_t;
endpackage

// File: rtl/stepDivCtrl.sv
module stepDivCtrl
  import stepDivPkg::*;
#(
  parameter int QW = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        stepEn,
  output logic        busy,
  output logic        done,
  output divStrobes_t stb
);
  localparam int STEPS = QW + 3;
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] FIRST_ITER = CW'(1);
  localparam logic [CW-1:0] LAST_ITER  = CW'(QW);
  localparam logic [CW-1:0] FIX_STEP   = CW'(QW + 1);
  localparam logic [CW-1:0] LAST_STEP  = CW'(STEPS - 1);

  logic [CW-1:0] stepCnt;
  logic          advance;

  assign advance = busy && stepEn;

  always_comb begin
    stb = '0;
    stb.load = start && !busy;
    if (advance) begin
      if (stepCnt == '0)
        stb.setup = 1'b1;
      else if (stepCnt >= FIRST_ITER && stepCnt <= LAST_ITER)
        stb.iter = 1'b1;
      else if (stepCnt == FIX_STEP)
        stb.fix = 1'b1;
      else if (stepCnt == LAST_STEP)
        stb.wb = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= 1'b0;
      if (stb.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (advance) begin
        if (stepCnt == LAST_STEP) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          stepCnt <= '0;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(stepCnt) == LAST_STEP); // R2
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy && !stepEn |=> busy && $stable(stepCnt)); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy && stepCnt == '0); // R1
endmodule

// File: rtl/stepDivPath.sv
module stepDivPath
  import stepDivPkg::*;
#(
  parameter int QW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobes_t       stb,
  input  logic [2*QW-1:0]   dividend,
  input  logic [QW-1:0]     divisor,
  input  logic              wideMode,
  input  logic              signedMode,
  output logic [QW-1:0]     quotient,
  output logic [QW-1:0]     remainder,
  output logic              divZero,
  output logic              overflow
);
  localparam int DW = 2 * QW;
  localparam logic [QW-1:0] HALF = {1'b1, {(QW-1){1'b0}}};

  logic [DW-1:0] dvdRaw;
  logic [QW-1:0] dvsRaw;
  logic          wideR;
  logic          sgnR;

  logic [QW-1:0] remR;
  logic [QW-1:0] quoR;
  logic [QW-1:0] dvsMag;
  logic          negQ;
  logic          negR;
  logic          dzR;
  logic          ovR;

  logic [DW-1:0] dvdExt;
  logic          dvdNeg;
  logic [DW-1:0] dvdMag;
  logic          dvsNeg;
  logic [QW-1:0] dvsAbs;
  logic          dvsIsZero;

  logic [QW:0]   shifted;
  logic [QW:0]   diff;
  logic          take;
  logic [QW-1:0] nextRem;
  logic          fixOverflow;

  always_comb begin
    if (wideR)
      dvdExt = dvdRaw;
    else if (sgnR)
      dvdExt = {{QW{dvdRaw[QW-1]}}, dvdRaw[QW-1:0]};
    else
      dvdExt = {{QW{1'b0}}, dvdRaw[QW-1:0]};
    dvdNeg    = sgnR && dvdExt[DW-1];
    dvdMag    = dvdNeg ? (~dvdExt + 1'b1) : dvdExt;
    dvsNeg    = sgnR && dvsRaw[QW-1];
    dvsAbs    = dvsNeg ? (~dvsRaw + 1'b1) : dvsRaw;
    dvsIsZero = (dvsRaw == '0);
  end

  always_comb begin
    shifted = {remR, quoR[QW-1]};
    diff    = shifted - {1'b0, dvsMag};
    take    = !diff[QW];
    nextRem = take ? diff[QW-1:0] : shifted[QW-1:0];
  end

  assign fixOverflow = wideR && sgnR && !dzR &&
                       (negQ ? (quoR > HALF) : quoR[QW-1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dvdRaw <= '0;
      dvsRaw <= '0;
      wideR  <= 1'b0;
      sgnR   <= 1'b0;
    end else if (stb.load) begin
      dvdRaw <= dividend;
      dvsRaw <= divisor;
      wideR  <= wideMode;
      sgnR   <= signedMode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR   <= '0;
      quoR   <= '0;
      dvsMag <= '0;
      negQ   <= 1'b0;
      negR   <= 1'b0;
      dzR    <= 1'b0;
      ovR    <= 1'b0;
    end else if (stb.setup) begin
      remR   <= dvdMag[DW-1:QW];
      quoR   <= dvdMag[QW-1:0];
      dvsMag <= dvsAbs;
      negQ   <= dvdNeg ^ dvsNeg;
      negR   <= dvdNeg;
      dzR    <= dvsIsZero;
      ovR    <= wideR && !dvsIsZero && (dvdMag[DW-1:QW] >= dvsAbs);
    end else if (stb.iter) begin
      remR <= nextRem;
      quoR <= {quoR[QW-2:0], take};
    end else if (stb.fix) begin
      quoR <= negQ ? (~quoR + 1'b1) : quoR;
      remR <= negR ? (~remR + 1'b1) : remR;
      if (fixOverflow)
        ovR <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quotient  <= '0;
      remainder <= '0;
      divZero   <= 1'b0;
      overflow  <= 1'b0;
    end else if (stb.wb) begin
      quotient  <= dzR ? '1 : quoR;
      remainder <= dzR ? dvdRaw[QW-1:0] : remR;
      divZero   <= dzR;
      overflow  <= ovR;
    end
  end

  AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.setup || stb.iter || stb.fix) |=> $stable(remR) && $stable(quoR)); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wb |=> $stable(quotient) && $stable(remainder) && $stable(divZero) && $stable(overflow)); // R10
  AST_DZ_QUOT: assert property (@(posedge clk) disable iff (!rstN)
    divZero |-> quotient == '1); // R7
  AST_DZ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    divZero |-> !overflow); // R7
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stb.iter && !ovR && !dzR |=> remR < dvsMag); // R5
  AST_NARROW_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.wb && !wideR |=> !overflow); // R8
endmodule

// File: rtl/stepDivider.sv
module stepDivider
  import stepDivPkg::*;
#(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [31:0]   dividend,
  input  logic [15:0]   divisor,
  input  logic          wideMode,
  input  logic          signedMode,
  input  logic          stepEn,
  output logic          busy,
  output logic          done,
  output logic [15:0]   quotient,
  output logic [15:0]   remainder,
  output logic          divZero,
  output logic          overflow
);
  divStrobes_t stb;

  stepDivCtrl #(.QW(QW)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .stepEn (stepEn),
    .busy   (busy),
    .done   (done),
    .stb    (stb)
  );

  stepDivPath #(.QW(QW)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .dividend   (dividend),
    .divisor    (divisor),
    .wideMode   (wideMode),
    .signedMode (signedMode),
    .quotient   (quotient),
    .remainder  (remainder),
    .divZero    (divZero),
    .overflow   (overflow)
  );
endmodule

// File: tb/tb_stepDivider.sv
module tb_stepDivider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        wideMode = 1'b0;
  logic        signedMode = 1'b0;
  logic        stepEn = 1'b0;
  logic        busy;
  logic        done;
  logic [15:0] quotient;
  logic [15:0] remainder;
  logic        divZero;
  logic        overflow;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  stepDivider dut (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend),
    .divisor(divisor), .wideMode(wideMode), .signedMode(signedMode),
    .stepEn(stepEn), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .divZero(divZero), .overflow(overflow)
  );

  // {wide, signed, dividend, divisor, expQ, expR, expDz, expOv}
  localparam int NV = 15;
  localparam logic [83:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h00000064, 16'h0007, 16'h000E, 16'h0002, 1'b0, 1'b0},
    {1'b0, 1'b0, 32'h0000FFFF, 16'h0001, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
    {1'b0, 1'b0, 32'hABCD0005, 16'h0009, 16'h0000, 16'h0005, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'h00012345, 16'h0010, 16'h1234, 16'h0005, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'hFFFEFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFE, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'h00010000, 16'h0001, 16'h0000, 16'h0000, 1'b0, 1'b1},
    {1'b0, 1'b1, 32'h0000FFF9, 16'h0002, 16'hFFFD, 16'hFFFF, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h00000007, 16'hFFFE, 16'hFFFD, 16'h0001, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h0000FFF9, 16'hFFFE, 16'h0003, 16'hFFFF, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h00008000, 16'hFFFF, 16'h8000, 16'h0000, 1'b0, 1'b0},
    {1'b1, 1'b1, 32'hFFFE7960, 16'h012C, 16'hFEB3, 16'hFF9C, 1'b0, 1'b0},
    {1'b1, 1'b1, 32'h00008000, 16'h0001, 16'h0000, 16'h0000, 1'b0, 1'b1},
    {1'b1, 1'b1, 32'hFFFF8000, 16'h0001, 16'h8000, 16'h0000, 1'b0, 1'b0},
    {1'b0, 1'b0, 32'h00001234, 16'h0000, 16'hFFFF, 16'h1234, 1'b1, 1'b0},
    {1'b1, 1'b1, 32'h87654321, 16'h0000, 16'hFFFF, 16'h4321, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  // Issue one divide; pauseLen > 0 withholds step enable before every fourth step.
  task automatic runOp(input logic w, input logic s, input logic [31:0] dd,
                       input logic [15:0] dv, input int pauseLen);
    bit earlyBad;
    @(negedge clk);
    wideMode = w; signedMode = s; dividend = dd; divisor = dv;
    start = 1'b1; stepEn = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R1", "busy after start", busy, 1);
    earlyBad = 0;
    for (int k = 0; k < 19; k++) begin
      if (pauseLen > 0 && (k % 4) == 2) begin
        stepEn = 1'b0;
        repeat (pauseLen) begin
          @(negedge clk);
          if (!busy || done) earlyBad = 1;
        end
      end
      stepEn = 1'b1;
      @(negedge clk);
      if (k < 18 && (!busy || done)) earlyBad = 1;
    end
    stepEn = 1'b0;
    chk(!earlyBad, "R2", "busy held, done low before 19th step", earlyBad, 0);
    chk(done === 1'b1 && busy === 1'b0, "R2", "done/busy after 19th step",
        {done, busy}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [83:0] v;
    string tag;
    logic [15:0] hq, hr;

    repeat (3) @(negedge clk);
    chk({busy, done, quotient, remainder, divZero, overflow} === '0, "R9",
        "outputs in reset", {busy, done, quotient}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, done, quotient, remainder, divZero, overflow} === '0, "R9",
        "outputs after reset", {remainder, divZero, overflow}, 0);

    // step enable alone while idle
    stepEn = 1'b1;
    repeat (5) @(negedge clk);
    stepEn = 1'b0;
    chk(busy === 1'b0 && done === 1'b0, "R1", "stepEn while idle", {busy, done}, 0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      runOp(v[83], v[82], v[81:50], v[49:34], (i % 2) ? 3 : 0);
      if (v[1]) tag = "R7";
      else if (v[0]) tag = "R8";
      else if (v[82]) tag = "R6";
      else if (v[83]) tag = "R5";
      else tag = "R4";
      if (!v[0]) begin
        chk(quotient === v[33:18], tag, $sformatf("quotient vec %0d", i), quotient, v[33:18]);
        chk(remainder === v[17:2], tag, $sformatf("remainder vec %0d", i), remainder, v[17:2]);
      end
      chk(divZero === v[1], tag, $sformatf("divZero vec %0d", i), divZero, v[1]);
      chk(overflow === v[0], tag, $sformatf("overflow vec %0d", i), overflow, v[0]);
      @(negedge clk);
      chk(done === 1'b0, "R2", "done single pulse", done, 0);
    end

    // R3: long pause mid-iteration
    runOp(1'b0, 1'b0, 32'h00000064, 16'h0007, 40);
    chk(quotient === 16'h000E && remainder === 16'h0002, "R3",
        "result after long pauses", {quotient, remainder}, {16'h000E, 16'h0002});

    // R1: start and operand change while busy are ignored
    @(negedge clk);
    wideMode = 1'b0; signedMode = 1'b0; dividend = 32'h00000064; divisor = 16'h0007;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 19; k++) begin
      if (k == 5) begin
        start = 1'b1; dividend = 32'h00001000; divisor = 16'h0001;
      end else begin
        start = 1'b0;
      end
      stepEn = 1'b1;
      @(negedge clk);
    end
    stepEn = 1'b0; start = 1'b0;
    chk(done === 1'b1, "R1", "done with restart ignored", done, 1);
    chk(quotient === 16'h000E && remainder === 16'h0002, "R1",
        "start while busy ignored", {quotient, remainder}, {16'h000E, 16'h0002});

    // R10: outputs hold between divides
    hq = quotient; hr = remainder;
    dividend = 32'h12345678; divisor = 16'h0003; wideMode = 1'b1;
    for (int k = 0; k < 10; k++) begin
      stepEn = k[0];
      @(negedge clk);
    end
    stepEn = 1'b0;
    chk(quotient === hq && remainder === hr && !divZero && !overflow, "R10",
        "outputs hold while idle", {quotient, remainder}, {hq, hr});

    summary();
    $finish;
  end
endmodule